// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block is the sending half of an inter-processor interrupt path. Software programs a 64-bit command through two 32-bit registers in a small register window. The upper word holds the target identifier. The lower word holds the vector, the delivery mode, the trigger and level bits and the broadcast flag. A write to the lower word starts a send. The unit then offers one message on a valid/ready port toward an interconnect model and holds it there until the port accepts it.

A read-only status bit in the lower word reads 1 while a message is waiting for acceptance. Software polls that bit before it issues the next command. A lower-word write that arrives while the bit is set is dropped, so the message in flight keeps its contents. The upper word keeps its value from one send to the next, so a series of commands to the same target only needs to rewrite the lower word. Starting another processor follows a fixed pattern: an INIT command, then startup commands whose vector field carries the entry address divided by 4096.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid_o is 0 and both command words read back as 0. Any address other than byte offset 0x300 (lower word) or 0x310 (upper word) reads 0.
- R2: A write to offset 0x300 while idle raises msg_valid_o in the next cycle. The message then carries vector = bits 7:0, mode = bits 10:8 (000 fixed, 101 INIT, 110 startup), assert = bit 14, level = bit 15, broadcast = bit 19, and destination = bits 31:24 of the upper word.
- R3: Bit 12 of the lower-word readback is the status flag. It reads 1 from the cycle after a send starts until the cycle after the message is accepted. A value written to bit 12 has no effect.
- R4: While msg_valid_o is 1 and msg_ready_i is 0, msg_valid_o stays 1 and every message field stays unchanged.
- R5: The cycle after a clock edge with msg_valid_o and msg_ready_i both 1, msg_valid_o and the status flag are 0. msg_ready_i has no effect while idle.
- R6: A lower-word write while the status flag is 1 is ignored: the message fields and the lower-word readback keep their values. This includes a write in the same cycle as the accepting handshake.
- R7: A write to offset 0x310 never starts a send. The upper word keeps its value across sends. An upper-word write while a message is pending does not change that message's destination. Only bits 31:24 of the upper word are stored.
- R8: For a startup command (mode 110), the vector field carries the start page. The emitted vector equals the entry address shifted right by 12.
- R9: The lower-word readback returns the stored vector, mode, assert, level and broadcast bits at their write positions. All other bits except the status flag read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte offset for both reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted when high with msg_valid_o |
| msg_vector_o | output | 8 | Vector or start page |
| msg_mode_o | output | 3 | Delivery mode |
| msg_assert_o | output | 1 | 1 = assert, 0 = deassert |
| msg_level_o | output | 1 | 1 = level, 0 = edge |
| msg_bcast_o | output | 1 | Broadcast to all units including the sender |
| msg_dest_o | output | 8 | Target identifier |

## Verification
The hardest case to reach is a new command that arrives while a message is stalled. The worst form of it is a lower-word write that lands on the very edge where the handshake completes. The stimulus holds msg_ready_i low for a count that changes from command to command. During that stall it issues conflicting lower-word and upper-word writes. On some commands it raises msg_ready_i in the same cycle as a lower-word write. A sweep covers every mode against the assert, level and broadcast combinations. Junk bits in the write data check the field masking.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W    = 32;
  localparam int VEC_W     = 8;
  localparam int MODE_W    = 3;
  localparam int DEST_W    = 8;
  localparam int MODE_LSB  = 8;
  localparam int BUSY_BIT  = 12;
  localparam int ASRT_BIT  = 14;
  localparam int LEVEL_BIT = 15;
  localparam int BCAST_BIT = 19;
  localparam int DEST_LSB  = 24;

  localparam logic [MODE_W-1:0] MODE_FIXED = 3'b000;
  localparam logic [MODE_W-1:0] MODE_INIT  = 3'b101;
  localparam logic [MODE_W-1:0] MODE_START = 3'b110;

  localparam logic [WORD_W-1:0] LOW_MASK =
      WORD_W'((1 << VEC_W) - 1)
    | (WORD_W'((1 << MODE_W) - 1) << MODE_LSB)
    | (WORD_W'(1) << ASRT_BIT)
    | (WORD_W'(1) << LEVEL_BIT)
    | (WORD_W'(1) << BCAST_BIT);

  localparam logic [WORD_W-1:0] HIGH_MASK = WORD_W'((1 << DEST_W) - 1) << DEST_LSB;

  typedef struct packed {
    logic             bcast;
    logic             level;
    logic             asrt;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } ipi_low_t;
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LOW_OFFS  = 'h300,
  parameter int HIGH_OFFS = 'h310
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              launch_o,
  output ipi_low_t          cmd_o,
  output logic [DEST_W-1:0] dest_o
);
  logic              sel_lo, sel_hi;
  logic [WORD_W-1:0] lo_q, hi_q;

  assign sel_lo   = (addr_i == ADDR_W'(LOW_OFFS));
  assign sel_hi   = (addr_i == ADDR_W'(HIGH_OFFS));
  assign launch_o = we_i & sel_lo & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (launch_o)      lo_q <= wdata_i & LOW_MASK;
      if (we_i && sel_hi) hi_q <= wdata_i & HIGH_MASK;
    end
  end

  always_comb begin
    if (sel_lo)      rdata_o = lo_q | (WORD_W'(busy_i) << BUSY_BIT);
    else if (sel_hi) rdata_o = hi_q;
    else             rdata_o = '0;
  end

  assign cmd_o.vector = lo_q[VEC_W-1:0];
  assign cmd_o.mode   = lo_q[MODE_LSB +: MODE_W];
  assign cmd_o.asrt   = lo_q[ASRT_BIT];
  assign cmd_o.level  = lo_q[LEVEL_BIT];
  assign cmd_o.bcast  = lo_q[BCAST_BIT];
  assign dest_o       = hi_q[DEST_LSB +: DEST_W];
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              ready_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic              valid_o,
  output logic [DEST_W-1:0] dest_o
);
  logic              valid_q;
  logic [DEST_W-1:0] dest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dest_q  <= '0;
    end else if (launch_i) begin
      valid_q <= 1'b1;
      dest_q  <= dest_i;  // snapshot: later upper-word writes stay out of the message
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign dest_o  = dest_q;

  a_r2_launch_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> valid_o);
  a_r4_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(dest_o)));
  a_r5_clear_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> !valid_o);
  a_r6_no_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !launch_i);
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LOW_OFFS  = 'h300,
  parameter int HIGH_OFFS = 'h310
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [7:0]        msg_vector_o,
  output logic [2:0]        msg_mode_o,
  output logic              msg_assert_o,
  output logic              msg_level_o,
  output logic              msg_bcast_o,
  output logic [7:0]        msg_dest_o
);
  logic              launch;
  logic              busy;
  ipi_low_t          cmd;
  logic [DEST_W-1:0] hi_dest;

  ipi_cmd_regs #(
    .ADDR_W   (ADDR_W),
    .LOW_OFFS (LOW_OFFS),
    .HIGH_OFFS(HIGH_OFFS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .busy_i  (busy),
    .rdata_o (bus_rdata_o),
    .launch_o(launch),
    .cmd_o   (cmd),
    .dest_o  (hi_dest)
  );

  ipi_launch u_launch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .ready_i (msg_ready_i),
    .dest_i  (hi_dest),
    .valid_o (busy),
    .dest_o  (msg_dest_o)
  );

  assign msg_valid_o  = busy;
  assign msg_vector_o = cmd.vector;
  assign msg_mode_o   = cmd.mode;
  assign msg_assert_o = cmd.asrt;
  assign msg_level_o  = cmd.level;
  assign msg_bcast_o  = cmd.bcast;

  a_r3_status_reads_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(LOW_OFFS)) |-> (bus_rdata_o[BUSY_BIT] == msg_valid_o));
  a_r6_busy_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(LOW_OFFS) && msg_valid_o)
      |=> $stable({msg_vector_o, msg_mode_o, msg_assert_o, msg_level_o, msg_bcast_o}));
  a_r7_high_no_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(HIGH_OFFS) && !msg_valid_o) |=> !msg_valid_o);
  a_r4_fields_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i)
      |=> $stable({msg_vector_o, msg_mode_o, msg_assert_o, msg_level_o, msg_bcast_o}));
endmodule

// File: tb/ipi_cmd_unit_tb.sv
module ipi_cmd_unit_tb;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_LO = 12'h300;
  localparam logic [11:0] A_HI = 12'h310;
  localparam logic [31:0] LO_KEEP = 32'h0008_C7FF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        msg_valid_o;
  logic        msg_ready_i = 1'b0;
  logic [7:0]  msg_vector_o;
  logic [2:0]  msg_mode_o;
  logic        msg_assert_o, msg_level_o, msg_bcast_o;
  logic [7:0]  msg_dest_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ipi_cmd_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i), .msg_vector_o(msg_vector_o), .msg_mode_o(msg_mode_o),
    .msg_assert_o(msg_assert_o), .msg_level_o(msg_level_o), .msg_bcast_o(msg_bcast_o),
    .msg_dest_o(msg_dest_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  function automatic logic [31:0] fields_of(input logic [31:0] w);
    return {18'd0, w[19], w[15], w[14], w[10:8], w[7:0]};
  endfunction

  function automatic logic [31:0] msg_now();
    return {18'd0, msg_bcast_o, msg_level_o, msg_assert_o, msg_mode_o, msg_vector_o};
  endfunction

  logic [31:0] hi_model;

  // one command: optional upper-word write, launch, stall, then accept
  task automatic send(input logic [31:0] w, input int stall, input bit do_hi,
                      input logic [31:0] hw, input bit collide);
    logic [31:0] r;
    logic [7:0]  dexp;
    if (do_hi) begin
      wr(A_HI, hw);
      hi_model = hw & HI_KEEP;
      chk("R7 high write no send", {31'd0, msg_valid_o}, 32'd0);
      rd(A_HI, r);
      chk("R7 high readback", r, hi_model);
    end
    dexp = hi_model[31:24];
    wr(A_LO, w);
    chk("R2 valid after low write", {31'd0, msg_valid_o}, 32'd1);
    chk("R2 fields", msg_now(), fields_of(w));
    chk("R2 dest", {24'd0, msg_dest_o}, {24'd0, dexp});
    rd(A_LO, r);
    chk("R9 R3 low readback busy", r, (w & LO_KEEP) | 32'h0000_1000);
    if (stall > 0) begin
      wr(A_LO, ~w);
      chk("R6 busy low write fields", msg_now(), fields_of(w));
      rd(A_LO, r);
      chk("R6 busy low readback", r, (w & LO_KEEP) | 32'h0000_1000);
      wr(A_HI, {~dexp, 24'h5A5A5A});
      hi_model = {~dexp, 24'd0};
      chk("R7 dest kept in flight", {24'd0, msg_dest_o}, {24'd0, dexp});
      for (int i = 2; i < stall; i++) begin
        @(negedge clk);
        chk("R4 valid held", {31'd0, msg_valid_o}, 32'd1);
        chk("R4 fields held", msg_now(), fields_of(w));
      end
    end
    @(negedge clk);
    msg_ready_i = 1'b1;
    if (collide) begin
      bus_we_i = 1'b1; bus_addr_i = A_LO; bus_wdata_i = ~w;
    end
    @(negedge clk);
    msg_ready_i = 1'b0; bus_we_i = 1'b0;
    chk("R5 valid cleared", {31'd0, msg_valid_o}, 32'd0);
    rd(A_LO, r);
    chk("R3 R6 status clear, collide write dropped", r, w & LO_KEEP);
  endtask

  initial begin
    logic [31:0] r, w, ea;
    hi_model = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 reset valid", {31'd0, msg_valid_o}, 32'd0);
    rd(A_LO, r); chk("R1 reset low", r, 32'd0);
    rd(A_HI, r); chk("R1 reset high", r, 32'd0);
    rd(12'h304, r); chk("R1 unmapped read", r, 32'd0);
    // ready while idle must not create a message
    @(negedge clk); msg_ready_i = 1'b1;
    @(negedge clk); msg_ready_i = 1'b0;
    chk("R5 ready idle no effect", {31'd0, msg_valid_o}, 32'd0);

    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 6; k++) begin
        w = 32'((m * 37 + k * 11) & 8'hFF) | (32'(m) << 8)
          | (32'(k & 1) << 14) | (32'((k >> 1) & 1) << 15) | (32'((m + k) & 1) << 19);
        if (k[0]) w = w | 32'hFF02_3800;  // junk incl. status bit 12
        send(w, k % 4, (k != 5), (32'(m * 16 + k + 1) << 24) | 32'h00AB_CDEF, (k == 2));
      end
    end

    // R8 startup pattern: INIT assert, INIT deassert, two startup commands
    send(32'h0000_C500, 0, 1'b1, 32'h0300_0000, 1'b0);
    send(32'h0000_8500, 1, 1'b1, 32'h0300_0000, 1'b0);
    ea = 32'h0007_0000;
    for (int j = 0; j < 2; j++) begin
      w = 32'h0000_0600 | (ea >> 12);
      wr(A_HI, 32'h0300_0000); hi_model = 32'h0300_0000;
      wr(A_LO, w);
      chk("R8 startup vector is page", {24'd0, msg_vector_o}, 32'h70);
      chk("R8 startup mode", {29'd0, msg_mode_o}, 32'd6);
      @(negedge clk); msg_ready_i = 1'b1;
      @(negedge clk); msg_ready_i = 1'b0;
      chk("R5 startup accepted", {31'd0, msg_valid_o}, 32'd0);
    end
    ea = 32'h000F_F000;
    send(32'h0000_0600 | (ea >> 12), 2, 1'b1, 32'h0900_0000, 1'b0);

    // ready already high at launch: accepted on the first valid cycle
    @(negedge clk); msg_ready_i = 1'b1;
    wr(A_LO, 32'h0000_0042);
    chk("R2 launch with ready high", {31'd0, msg_valid_o}, 32'd1);
    @(negedge clk);
    chk("R5 immediate accept clears", {31'd0, msg_valid_o}, 32'd0);
    msg_ready_i = 1'b0;
    // back-to-back command accepted once status is clear
    wr(A_LO, 32'h0008_0031);
    chk("R3 next command after clear", msg_now(), fields_of(32'h0008_0031));
    @(negedge clk); msg_ready_i = 1'b1;
    @(negedge clk); msg_ready_i = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule